// File: doc/BRIEF.md
# Wheel-Stall Unlock Detector

This block belongs to an anti-lock braking controller. It watches two single-cycle pulse inputs. `wheelPulse` fires once each time the wheel turns through a small fixed angle. `tickPulse` is a periodic timebase strobe that arrives once every 10 ms. The block counts timebase ticks since the most recent wheel pulse. When that count reaches a configured threshold, the wheel is treated as stalled and the block raises `unlock` so the brake can be released.

Any wheel pulse clears the count and drops `unlock` on the next clock edge. A wheel pulse that arrives in the same cycle as a tick takes priority, and that tick is lost. Once `unlock` is high, further ticks hold it high. The count saturates at the threshold and never wraps.

The threshold is the parameter `TICKS_TO_UNLOCK`. Its default is 2 and its minimum is 1. `unlock` is a registered Moore output. Reset is synchronous and active high.

Top module: `wheel_stall_unlock`

## Requirements
- R1: While `rst` is sampled high at a rising edge, the block returns to its empty state. After that edge `unlock` is 0 and the tick count is 0, so a full `TICKS_TO_UNLOCK` new ticks are needed to raise `unlock`.
- R2: Suppose the edge samples `tickPulse`=1 and `wheelPulse`=0, and this is the `TICKS_TO_UNLOCK`-th tick counted since the last wheel pulse or reset. Then `unlock` is 1 after that edge.
- R3: While fewer than `TICKS_TO_UNLOCK` ticks have been counted since the last wheel pulse or reset, `unlock` stays 0.
- R4: An edge that samples `wheelPulse`=1 leaves `unlock` at 0 after that edge and clears the tick count to 0.
- R5: An edge that samples `wheelPulse`=1 and `tickPulse`=1 together behaves exactly like a wheel pulse alone. The tick is not counted.
- R6: While `unlock` is 1, ticks with no wheel pulse keep it at 1 for any number of ticks. The internal count saturates at `TICKS_TO_UNLOCK` and never wraps. After a later wheel pulse, `TICKS_TO_UNLOCK`-1 ticks still leave `unlock` at 0.
- R7: An edge that samples both pulse inputs low leaves `unlock` unchanged.
- R8: `TICKS_TO_UNLOCK` must be at least 1. When it is 1, a single tick after a wheel pulse or reset raises `unlock`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| wheelPulse | input | 1 | One-cycle pulse per small wheel rotation increment |
| tickPulse | input | 1 | One-cycle periodic timebase pulse |
| unlock | output | 1 | Registered brake-release request |

## Verification
Every result is due one edge after the stimulus that causes it. The pulses are sampled at a rising edge, and `unlock` takes its new value at that same edge with no further register on the way. The bench changes inputs on the falling edge and lets one rising edge sample them. It compares `unlock` at the following falling edge against a count-based expectation, so each check lands exactly one edge after its stimulus. An exhaustive sweep of every five-cycle sequence of the four input combinations, each run from reset, covers every pairing of the pulses. A long tick run then probes saturation.

// File: rtl/stall_pkg.sv
package stall_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_COUNTING = 2'd1,
    ST_UNLOCKED = 2'd2
  } stallState_t;

  typedef struct packed {
    logic clearCount;
    logic stepCount;
  } dpStrobes_t;

endpackage

// File: rtl/stall_tick_counter.sv
module stall_tick_counter
  import stall_pkg::*;
#(
  parameter int LIMIT = 2,
  localparam int CNT_W = $clog2(LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  dpStrobes_t       strobes,
  output logic [CNT_W-1:0] tickCount,
  output logic             atLastStep
);

  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(LIMIT);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LIMIT - 1);

  // Saturating tick counter; clear has priority over step.
  always_ff @(posedge clk) begin
    if (rst) begin
      tickCount <= '0;
    end else if (strobes.clearCount) begin
      tickCount <= '0;
    end else if (strobes.stepCount && (tickCount < CNT_MAX)) begin
      tickCount <= tickCount + 1'b1;
    end
  end

  // One more tick reaches the threshold.
  assign atLastStep = (tickCount == CNT_LAST);

endmodule

// File: rtl/stall_ctrl.sv
module stall_ctrl
  import stall_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wheelPulse,
  input  logic       tickPulse,
  input  logic       atLastStep,
  output dpStrobes_t strobes,
  output logic       unlock
);

  stallState_t stateQ;
  stallState_t stateD;

  always_comb begin
    stateD = stateQ;
    if (wheelPulse) begin
      stateD = ST_IDLE;
    end else if (tickPulse) begin
      unique case (stateQ)
        ST_IDLE, ST_COUNTING: stateD = atLastStep ? ST_UNLOCKED : ST_COUNTING;
        ST_UNLOCKED:          stateD = ST_UNLOCKED;
        default:              stateD = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.clearCount = wheelPulse;
    strobes.stepCount  = tickPulse && !wheelPulse && (stateQ != ST_UNLOCKED);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= ST_IDLE;
      unlock <= 1'b0;
    end else begin
      stateQ <= stateD;
      unlock <= (stateD == ST_UNLOCKED);
    end
  end

endmodule

// File: rtl/wheel_stall_unlock.sv
module wheel_stall_unlock
  import stall_pkg::*;
#(
  parameter int TICKS_TO_UNLOCK = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic wheelPulse,
  input  logic tickPulse,
  output logic unlock
);

  localparam int CNT_W = $clog2(TICKS_TO_UNLOCK + 1);

  generate
    if (TICKS_TO_UNLOCK < 1) begin : g_badLimit
      $error("TICKS_TO_UNLOCK must be at least 1");
    end
  endgenerate

  dpStrobes_t       strobes;
  logic [CNT_W-1:0] tickCount;
  logic             atLastStep;

  stall_ctrl ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .wheelPulse (wheelPulse),
    .tickPulse  (tickPulse),
    .atLastStep (atLastStep),
    .strobes    (strobes),
    .unlock     (unlock)
  );

  stall_tick_counter #(.LIMIT(TICKS_TO_UNLOCK)) count_i (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .tickCount  (tickCount),
    .atLastStep (atLastStep)
  );

endmodule

// File: rtl/wheel_stall_unlock_checker.sv
module wheel_stall_unlock_checker #(
  parameter int LIMIT = 2,
  localparam int CNT_W = $clog2(LIMIT + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             wheelPulse,
  input logic             tickPulse,
  input logic             unlock,
  input logic [CNT_W-1:0] tickCount
);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> (!unlock && tickCount == '0)); // R1

  AST_RISE_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(unlock) |-> ($past(tickPulse) && !$past(wheelPulse))); // R2

  AST_LOW_BELOW_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (tickCount < CNT_W'(LIMIT)) |-> !unlock); // R3

  AST_WHEEL_CLEARS: assert property (@(posedge clk) disable iff (rst)
    wheelPulse |=> (!unlock && tickCount == '0)); // R4

  AST_WHEEL_WINS: assert property (@(posedge clk) disable iff (rst)
    (wheelPulse && tickPulse) |=> (tickCount == '0)); // R5

  AST_HOLD_UNLOCK: assert property (@(posedge clk) disable iff (rst)
    (unlock && !wheelPulse) |=> unlock); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    tickCount <= CNT_W'(LIMIT)); // R6

  AST_QUIET_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!wheelPulse && !tickPulse) |=> $stable(unlock)); // R7

endmodule

bind wheel_stall_unlock wheel_stall_unlock_checker #(.LIMIT(TICKS_TO_UNLOCK)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .wheelPulse (wheelPulse),
  .tickPulse  (tickPulse),
  .unlock     (unlock),
  .tickCount  (tickCount)
);

// File: tb/wheel_stall_unlock_tb_top.sv
module wheel_stall_unlock_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TICKS = 2;
  localparam int SEQ_LEN = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wheelIn = 1'b0;
  logic tickIn = 1'b0;
  logic unlockOut;
  logic unlockOne;

  int checks = 0;
  int errors = 0;
  int refCount = 0;
  logic refUnlock = 1'b0;
  int refCountOne = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wheel_stall_unlock #(.TICKS_TO_UNLOCK(TICKS)) dut_i (
    .clk(clk), .rst(rst), .wheelPulse(wheelIn), .tickPulse(tickIn), .unlock(unlockOut)
  );

  // Threshold-of-one configuration for R8.
  wheel_stall_unlock #(.TICKS_TO_UNLOCK(1)) dut_one_i (
    .clk(clk), .rst(rst), .wheelPulse(wheelIn), .tickPulse(tickIn), .unlock(unlockOne)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: unlock actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic doReset();
    rst = 1'b1; wheelIn = 1'b0; tickIn = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    refCount = 0; refUnlock = 1'b0; refCountOne = 0;
    check("R1", unlockOut, 1'b0);
    check("R1", unlockOne, 1'b0);
  endtask

  task automatic cycle(input logic w, input logic t);
    string tag;
    logic prevUnlock;
    prevUnlock = refUnlock;
    wheelIn = w; tickIn = t;
    @(posedge clk);
    if (w) begin
      refCount = 0; refCountOne = 0;
    end else if (t) begin
      if (refCount < TICKS) refCount++;
      if (refCountOne < 1) refCountOne++;
    end
    refUnlock = (refCount >= TICKS);
    if (w && t)                    tag = "R5";
    else if (w)                    tag = "R4";
    else if (!t)                   tag = "R7";
    else if (prevUnlock)           tag = "R6";
    else if (refUnlock)            tag = "R2";
    else                           tag = "R3";
    @(negedge clk);
    wheelIn = 1'b0; tickIn = 1'b0;
    check(tag, unlockOut, refUnlock);
    check("R8", unlockOne, refCountOne >= 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    // Exhaustive sweep: every 5-cycle sequence over {wheel,tick}.
    for (int seq = 0; seq < (1 << (2 * SEQ_LEN)); seq++) begin
      doReset();
      for (int k = 0; k < SEQ_LEN; k++) begin
        cycle(seq[2 * k + 1], seq[2 * k]);
      end
    end
    // Long tick run: saturation, no wrap (R6).
    doReset();
    for (int k = 0; k < 40; k++) begin
      cycle(1'b0, 1'b1);
      cycle(1'b0, 1'b0);
    end
    check("R6", unlockOut, 1'b1);
    cycle(1'b1, 1'b0);
    for (int k = 0; k < TICKS - 1; k++) cycle(1'b0, 1'b1);
    check("R6", unlockOut, 1'b0);
    cycle(1'b0, 1'b1);
    check("R2", unlockOut, 1'b1);
    // Mid-run reset clears a stalled state (R1).
    doReset();
    for (int k = 0; k < TICKS - 1; k++) cycle(1'b0, 1'b1);
    check("R1", unlockOut, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule